// File: doc/BRIEF.md
# Version-Checked Shared Access Gate

This block sits beside one processor core and rules on every shared load or store that the running task issues. The answer is one of three: grant, stall or trap. A task first installs one local entry per shared address it will touch. Each entry holds the acquire number, the release number, the delta, the expected reader count and a read-only flag. Installing an entry also adds the address to a counting Bloom filter.

An access whose address misses the filter is granted at once, and the global version store is not touched. On a filter hit the local table is searched. A table miss raises a trap so that software can step in. A table hit fetches the location's global record, which holds a write number and a read number, and compares it with the entry. A match grants the access. A mismatch raises stall, and the block then re-reads the record every cycle until it matches.

A release reads the record and writes it back. A writer's release stores its release number as the new write number and clears the read number. A reader's release adds one to the read number. The release then frees the local entry and takes the address out of the filter.

Top module: `vsn_access_ctrl`

## Requirements
- R1: After a synchronous reset, grant, stall and trap are low, req_ready is high, and the filter is empty, so every request is granted without a version lookup.
- R2: A request whose address misses the filter is granted in the cycle after it is accepted. Such a request writes nothing to the global store and never stalls.
- R3: An address whose entry was installed always hits the filter. A request to it needs a global lookup, so its grant comes two cycles after acceptance.
- R4: A request that hits the filter but has no matching valid local entry raises trap for one cycle, in the cycle after acceptance.
- R5: A read (req_write=0) with a local entry is granted when the entry's acquire number equals the record's write number. The delta and the read number play no part in a read.
- R6: A write (req_write=1) with a local entry is granted only when the acquire number equals the write number and delta plus the read number, taken modulo 2^VER_W, equals the entry's expected reader count.
- R7: On a mismatch, stall rises two cycles after acceptance and req_ready stays low. The record is re-read every cycle, and grant comes once it matches, with stall dropping in that same cycle.
- R8: A release of an installed address finishes with a one-cycle grant two cycles after acceptance. A writer's release (read-only flag 0) writes {release number, 0} as {write number, read number}. A reader's release writes {write number, read number + 1}.
- R9: The filter uses 2 hash slots per address: the low SW address bits, and the next SW bits above them, where SW = log2(CBF_SLOTS). A release decrements both counters, but never below zero. A counter that has reached its maximum stays there.
- R10: The lowest free local entry takes a load. A load that arrives while all entries are valid is dropped, and the filter is left unchanged.
- R11: req_ready is high only while the block is idle. A request takes priority over a release offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_ready | output | 1 | Block idle; request or release is accepted this cycle |
| rel_valid | input | 1 | Release request present |
| rel_addr | input | ADDR_W | Address being released |
| ld_valid | input | 1 | Install a local entry |
| ld_addr | input | ADDR_W | Shared address of the new entry |
| ld_acq | input | VER_W | Acquire number |
| ld_rel | input | VER_W | Release number |
| ld_delta | input | VER_W | Delta number |
| ld_rtarget | input | VER_W | Expected reader count for writes |
| ld_readonly | input | 1 | Entry belongs to a read-only holder |
| grant | output | 1 | Access (or release) completed, one cycle |
| stall | output | 1 | Waiting for the version record to match |
| trap | output | 1 | Filter hit without a local entry, one cycle |
| gv_addr | output | GV_AW | Global version store address |
| gv_we | output | 1 | Global version store write enable |
| gv_wdata | output | 2*VER_W | Record to write: {write number, read number} |
| gv_rdata | input | 2*VER_W | Record read, one cycle after the address |

## Verification
The bench builds the block with 16 filter slots, 2-bit counters and 4 local entries. Small counters let four loads to addresses that share both hash slots saturate a counter, so the sticky-maximum rule can be seen as a trap after the releases. Sixteen slots make it easy to pick an unregistered address that lands on two occupied slots, which forces a false positive that leads to a trap. Four entries let one extra load meet a full table. An 8-bit version width and an 8-bit store index keep the bench's version memory small, and the bench rewrites it in the middle of a stall to release a waiting access.

// File: rtl/vsn_pkg.sv
package vsn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RELW  = 2'd2
  } vsn_state_t;
endpackage

// File: rtl/vsn_count_filter.sv
module vsn_count_filter #(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 256,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              q_hit,
  input  logic              inc_en,
  input  logic [ADDR_W-1:0] inc_addr,
  input  logic              dec_en,
  input  logic [ADDR_W-1:0] dec_addr
);
  localparam int SW = $clog2(SLOTS);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  function automatic logic [SW-1:0] hash_lo(input logic [ADDR_W-1:0] a);
    return a[SW-1:0];
  endfunction

  function automatic logic [SW-1:0] hash_hi(input logic [ADDR_W-1:0] a);
    return a[2*SW-1:SW];
  endfunction

  logic [CNT_W-1:0] cnt [SLOTS];
  logic [SLOTS-1:0] up_v, dn_v;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign up_v[g] = inc_en && ((hash_lo(inc_addr) == SW'(g)) || (hash_hi(inc_addr) == SW'(g)));
    assign dn_v[g] = dec_en && ((hash_lo(dec_addr) == SW'(g)) || (hash_hi(dec_addr) == SW'(g)));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (rst) begin
        cnt[i] <= '0;
      end else if (up_v[i] && !dn_v[i] && cnt[i] != CMAX) begin
        cnt[i] <= cnt[i] + 1'b1;
      end else if (dn_v[i] && !up_v[i] && cnt[i] != '0 && cnt[i] != CMAX) begin
        cnt[i] <= cnt[i] - 1'b1;
      end
    end
  end

  assign q_hit = (cnt[hash_lo(q_addr)] != '0) && (cnt[hash_hi(q_addr)] != '0);
endmodule

// File: rtl/vsn_local_table.sv
module vsn_local_table #(
  parameter int ADDR_W  = 32,
  parameter int VER_W   = 16,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [VER_W-1:0]  ld_acq,
  input  logic [VER_W-1:0]  ld_rel,
  input  logic [VER_W-1:0]  ld_delta,
  input  logic [VER_W-1:0]  ld_rtarget,
  input  logic              ld_readonly,
  output logic              ld_accept,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              look_hit,
  output logic [$clog2(ENTRIES)-1:0] look_idx,
  output logic [VER_W-1:0]  look_acq,
  output logic [VER_W-1:0]  look_rel,
  output logic [VER_W-1:0]  look_delta,
  output logic [VER_W-1:0]  look_rtarget,
  output logic              look_ro,
  input  logic              free_en,
  input  logic [$clog2(ENTRIES)-1:0] free_idx
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid;
  logic [ADDR_W-1:0]  t_addr  [ENTRIES];
  logic [VER_W-1:0]   t_acq   [ENTRIES];
  logic [VER_W-1:0]   t_rel   [ENTRIES];
  logic [VER_W-1:0]   t_delta [ENTRIES];
  logic [VER_W-1:0]   t_rtgt  [ENTRIES];
  logic [ENTRIES-1:0] t_ro;

  logic          have_free;
  logic [IW-1:0] free_slot;

  always_comb begin
    have_free = 1'b0;
    free_slot = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid[i] && !have_free) begin
        have_free = 1'b1;
        free_slot = IW'(i);
      end
    end
  end

  assign ld_accept = ld_en && have_free;

  always_comb begin
    look_hit = 1'b0;
    look_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid[i] && t_addr[i] == look_addr && !look_hit) begin
        look_hit = 1'b1;
        look_idx = IW'(i);
      end
    end
  end

  assign look_acq     = t_acq[look_idx];
  assign look_rel     = t_rel[look_idx];
  assign look_delta   = t_delta[look_idx];
  assign look_rtarget = t_rtgt[look_idx];
  assign look_ro      = t_ro[look_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
    end else begin
      if (free_en) valid[free_idx] <= 1'b0;
      if (ld_accept) valid[free_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_accept) begin
      t_addr[free_slot]  <= ld_addr;
      t_acq[free_slot]   <= ld_acq;
      t_rel[free_slot]   <= ld_rel;
      t_delta[free_slot] <= ld_delta;
      t_rtgt[free_slot]  <= ld_rtarget;
      t_ro[free_slot]    <= ld_readonly;
    end
  end
endmodule

// File: rtl/vsn_check_engine.sv
module vsn_check_engine
  import vsn_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int VER_W   = 16,
  parameter int ENTRIES = 8,
  parameter int GV_AW   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              req_ready,
  input  logic              rel_valid,
  input  logic [ADDR_W-1:0] rel_addr,
  input  logic              flt_hit,
  input  logic              lt_hit,
  input  logic [$clog2(ENTRIES)-1:0] lt_idx,
  input  logic [VER_W-1:0]  lt_acq,
  input  logic [VER_W-1:0]  lt_rel,
  input  logic [VER_W-1:0]  lt_delta,
  input  logic [VER_W-1:0]  lt_rtarget,
  input  logic              lt_ro,
  output logic              free_en,
  output logic [$clog2(ENTRIES)-1:0] free_idx,
  output logic              dec_en,
  output logic [ADDR_W-1:0] dec_addr,
  output logic              grant,
  output logic              stall,
  output logic              trap,
  output logic [GV_AW-1:0]  gv_addr,
  output logic              gv_we,
  output logic [2*VER_W-1:0] gv_wdata,
  input  logic [2*VER_W-1:0] gv_rdata
);
  localparam int IW = $clog2(ENTRIES);

  vsn_state_t state;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_wr;
  logic [VER_W-1:0]  e_acq, e_rel, e_delta, e_rtgt;
  logic              e_ro;
  logic [IW-1:0]     e_idx;

  logic [VER_W-1:0] gv_wnum, gv_rnum;
  logic             take_req, take_rel, match;

  assign gv_wnum = gv_rdata[2*VER_W-1:VER_W];
  assign gv_rnum = gv_rdata[VER_W-1:0];

  assign req_ready = (state == ST_IDLE);
  assign take_req  = req_ready && req_valid;
  assign take_rel  = req_ready && !req_valid && rel_valid;

  assign match = (gv_wnum == e_acq) &&
                 (!cur_wr || (VER_W'(e_delta + gv_rnum) == e_rtgt));

  always_comb begin
    if (state == ST_IDLE) gv_addr = req_valid ? req_addr[GV_AW-1:0] : rel_addr[GV_AW-1:0];
    else                  gv_addr = cur_addr[GV_AW-1:0];
  end

  assign gv_we    = (state == ST_RELW);
  assign gv_wdata = e_ro ? {gv_wnum, VER_W'(gv_rnum + 1'b1)} : {e_rel, {VER_W{1'b0}}};
  assign free_en  = (state == ST_RELW);
  assign free_idx = e_idx;
  assign dec_en   = (state == ST_RELW);
  assign dec_addr = cur_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      grant    <= 1'b0;
      stall    <= 1'b0;
      trap     <= 1'b0;
      cur_addr <= '0;
      cur_wr   <= 1'b0;
      e_acq    <= '0;
      e_rel    <= '0;
      e_delta  <= '0;
      e_rtgt   <= '0;
      e_ro     <= 1'b0;
      e_idx    <= '0;
    end else begin
      grant <= 1'b0;
      trap  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take_req || take_rel) begin
            cur_addr <= take_req ? req_addr : rel_addr;
            cur_wr   <= take_req && req_write;
            e_acq    <= lt_acq;
            e_rel    <= lt_rel;
            e_delta  <= lt_delta;
            e_rtgt   <= lt_rtarget;
            e_ro     <= lt_ro;
            e_idx    <= lt_idx;
          end
          if (take_req) begin
            if (!flt_hit)     grant <= 1'b1;
            else if (!lt_hit) trap  <= 1'b1;
            else              state <= ST_CHECK;
          end else if (take_rel) begin
            if (!lt_hit) trap  <= 1'b1;
            else         state <= ST_RELW;
          end
        end
        ST_CHECK: begin
          if (match) begin
            grant <= 1'b1;
            stall <= 1'b0;
            state <= ST_IDLE;
          end else begin
            stall <= 1'b1;
          end
        end
        ST_RELW: begin
          grant <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vsn_access_ctrl.sv
module vsn_access_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int VER_W     = 16,
  parameter int LT_ENTRIES = 8,
  parameter int CBF_SLOTS = 256,
  parameter int CNT_W     = 4,
  parameter int GV_AW     = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_write,
  output logic               req_ready,
  input  logic               rel_valid,
  input  logic [ADDR_W-1:0]  rel_addr,
  input  logic               ld_valid,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [VER_W-1:0]   ld_acq,
  input  logic [VER_W-1:0]   ld_rel,
  input  logic [VER_W-1:0]   ld_delta,
  input  logic [VER_W-1:0]   ld_rtarget,
  input  logic               ld_readonly,
  output logic               grant,
  output logic               stall,
  output logic               trap,
  output logic [GV_AW-1:0]   gv_addr,
  output logic               gv_we,
  output logic [2*VER_W-1:0] gv_wdata,
  input  logic [2*VER_W-1:0] gv_rdata
);
  localparam int IW = $clog2(LT_ENTRIES);

  logic              flt_hit, ld_accept, lt_hit, lt_ro;
  logic [IW-1:0]     lt_idx, free_idx;
  logic [VER_W-1:0]  lt_acq, lt_rel, lt_delta, lt_rtarget;
  logic              free_en, dec_en;
  logic [ADDR_W-1:0] dec_addr, look_addr;

  assign look_addr = req_valid ? req_addr : rel_addr;

  vsn_count_filter #(.ADDR_W(ADDR_W), .SLOTS(CBF_SLOTS), .CNT_W(CNT_W)) u_filter (
    .clk(clk), .rst(rst),
    .q_addr(req_addr), .q_hit(flt_hit),
    .inc_en(ld_accept), .inc_addr(ld_addr),
    .dec_en(dec_en), .dec_addr(dec_addr)
  );

  vsn_local_table #(.ADDR_W(ADDR_W), .VER_W(VER_W), .ENTRIES(LT_ENTRIES)) u_table (
    .clk(clk), .rst(rst),
    .ld_en(ld_valid), .ld_addr(ld_addr), .ld_acq(ld_acq), .ld_rel(ld_rel),
    .ld_delta(ld_delta), .ld_rtarget(ld_rtarget), .ld_readonly(ld_readonly),
    .ld_accept(ld_accept),
    .look_addr(look_addr), .look_hit(lt_hit), .look_idx(lt_idx),
    .look_acq(lt_acq), .look_rel(lt_rel), .look_delta(lt_delta),
    .look_rtarget(lt_rtarget), .look_ro(lt_ro),
    .free_en(free_en), .free_idx(free_idx)
  );

  vsn_check_engine #(.ADDR_W(ADDR_W), .VER_W(VER_W), .ENTRIES(LT_ENTRIES), .GV_AW(GV_AW)) u_engine (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_ready(req_ready),
    .rel_valid(rel_valid), .rel_addr(rel_addr),
    .flt_hit(flt_hit), .lt_hit(lt_hit), .lt_idx(lt_idx),
    .lt_acq(lt_acq), .lt_rel(lt_rel), .lt_delta(lt_delta), .lt_rtarget(lt_rtarget), .lt_ro(lt_ro),
    .free_en(free_en), .free_idx(free_idx), .dec_en(dec_en), .dec_addr(dec_addr),
    .grant(grant), .stall(stall), .trap(trap),
    .gv_addr(gv_addr), .gv_we(gv_we), .gv_wdata(gv_wdata), .gv_rdata(gv_rdata)
  );
endmodule

// File: rtl/vsn_access_ctrl_chk.sv
module vsn_access_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic rel_valid,
  input logic req_ready,
  input logic grant,
  input logic stall,
  input logic trap,
  input logic gv_we
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!grant && !stall && !trap));

  // R7
  outputs_excl_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({grant, stall, trap}));

  // R7
  stall_exit_chk: assert property (@(posedge clk) disable iff (rst) stall |=> (stall || grant));

  // R11
  stall_busy_chk: assert property (@(posedge clk) disable iff (rst) stall |-> !req_ready);

  // R4
  trap_after_idle_chk: assert property (@(posedge clk) disable iff (rst) trap |-> $past(req_ready));

  // R8
  store_write_chk: assert property (@(posedge clk) disable iff (rst)
    gv_we |-> $past(req_ready && !req_valid && rel_valid));
endmodule

bind vsn_access_ctrl vsn_access_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .rel_valid(rel_valid),
  .req_ready(req_ready), .grant(grant), .stall(stall), .trap(trap), .gv_we(gv_we)
);

// File: tb/vsn_access_ctrl_test.sv
module vsn_access_ctrl_test;
  localparam int AW = 16, VW = 8, NE = 4, SL = 16, CW = 2, GA = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, rel_valid = 0, ld_valid = 0, ld_readonly = 0;
  logic [AW-1:0] req_addr = '0, rel_addr = '0, ld_addr = '0;
  logic [VW-1:0] ld_acq = '0, ld_rel = '0, ld_delta = '0, ld_rtarget = '0;
  logic req_ready, grant, stall, trap, gv_we;
  logic [GA-1:0] gv_addr;
  logic [2*VW-1:0] gv_wdata, gv_rdata;
  logic [2*VW-1:0] gmem [1<<GA];

  int checks = 0, errors = 0, we_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vsn_access_ctrl #(.ADDR_W(AW), .VER_W(VW), .LT_ENTRIES(NE), .CBF_SLOTS(SL),
                    .CNT_W(CW), .GV_AW(GA)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_ready(req_ready), .rel_valid(rel_valid), .rel_addr(rel_addr),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_acq(ld_acq), .ld_rel(ld_rel),
    .ld_delta(ld_delta), .ld_rtarget(ld_rtarget), .ld_readonly(ld_readonly),
    .grant(grant), .stall(stall), .trap(trap),
    .gv_addr(gv_addr), .gv_we(gv_we), .gv_wdata(gv_wdata), .gv_rdata(gv_rdata)
  );

  initial for (int i = 0; i < (1<<GA); i++) gmem[i] = '0;

  always @(posedge clk) begin
    if (gv_we) begin
      gmem[gv_addr] <= gv_wdata;
      we_cnt <= we_cnt + 1;
    end
    gv_rdata <= gmem[gv_addr];
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_load(input [AW-1:0] a, input [VW-1:0] acq, input [VW-1:0] rl,
                         input [VW-1:0] dl, input [VW-1:0] rt, input bit ro);
    @(negedge clk);
    ld_valid = 1; ld_addr = a; ld_acq = acq; ld_rel = rl;
    ld_delta = dl; ld_rtarget = rt; ld_readonly = ro;
    @(negedge clk);
    ld_valid = 0;
  endtask

  // kind: 0 grant, 1 trap, 2 timeout; lat counted in cycles after acceptance
  task automatic do_req(input [AW-1:0] a, input bit wr, input int poke_at,
                        input [2*VW-1:0] pv, output int lat, output int kind,
                        output bit stall_seen, output bit busy_seen);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    lat = 1; kind = 2; stall_seen = 0; busy_seen = 0;
    for (int k = 0; k < 40; k++) begin
      if (grant) begin kind = 0; break; end
      if (trap)  begin kind = 1; break; end
      if (stall) stall_seen = 1;
      if (!req_ready) busy_seen = 1;
      if (lat == poke_at) gmem[a[GA-1:0]] = pv;
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic do_rel(input [AW-1:0] a, output int lat, output int kind);
    @(negedge clk);
    rel_valid = 1; rel_addr = a;
    @(negedge clk);
    rel_valid = 0;
    lat = 1; kind = 2;
    for (int k = 0; k < 20; k++) begin
      if (grant) begin kind = 0; break; end
      if (trap)  begin kind = 1; break; end
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset_and_miss();
    int lat, kind, w0; bit s, b;
    @(negedge clk);
    check(!grant && !stall && !trap, "R1 outputs idle after reset", {grant, stall, trap}, 0);
    check(req_ready, "R1 ready after reset", req_ready, 1);
    w0 = we_cnt;
    do_req(16'h0055, 1'b1, -1, '0, lat, kind, s, b);
    check(kind == 0 && lat == 1, "R2 filter miss grants next cycle", lat, 1);
    check(!s && we_cnt == w0, "R2 no store write or stall on miss", we_cnt - w0, 0);
  endtask

  task automatic t_hit_read();
    int lat, kind; bit s, b;
    gmem[8'h12] = {8'd4, 8'd0};
    do_load(16'h0012, 8'd4, 8'd6, 8'd0, 8'd0, 1'b1);
    do_req(16'h0012, 1'b0, -1, '0, lat, kind, s, b);
    check(kind == 0 && lat == 2, "R3 registered address takes lookup path", lat, 2);
    check(!s, "R5 read grants on acquire match", s, 0);
  endtask

  task automatic t_false_pos_trap();
    int lat, kind; bit s, b;
    do_load(16'h0034, 8'd1, 8'd2, 8'd1, 8'd2, 1'b0);
    do_req(16'h0014, 1'b0, -1, '0, lat, kind, s, b);
    check(kind == 1 && lat == 1, "R4 filter hit without entry traps", kind * 10 + lat, 11);
  endtask

  task automatic t_write_rule();
    int lat, kind; bit s, b;
    gmem[8'h34] = {8'd1, 8'd1};
    do_req(16'h0034, 1'b1, -1, '0, lat, kind, s, b);
    check(kind == 0 && lat == 2 && !s, "R6 write grants when delta+read matches", lat, 2);
    gmem[8'h34] = {8'd1, 8'd0};
    do_req(16'h0034, 1'b0, -1, '0, lat, kind, s, b);
    check(kind == 0 && lat == 2 && !s, "R5 read ignores read number", lat, 2);
    do_req(16'h0034, 1'b1, 5, {8'd1, 8'd1}, lat, kind, s, b);
    check(s && b, "R6 write stalls on read-count mismatch", s, 1);
    check(kind == 0 && lat > 5, "R7 write grants after record updated", lat, 7);
  endtask

  task automatic t_read_stall();
    int lat, kind; bit s, b;
    gmem[8'h12] = {8'd3, 8'd0};
    do_req(16'h0012, 1'b0, 4, {8'd4, 8'd0}, lat, kind, s, b);
    check(s && b, "R7 read stalls on write-number mismatch", s, 1);
    check(kind == 0 && lat > 4, "R7 grant after re-read matches", lat, 6);
    @(negedge clk);
    check(!stall && req_ready, "R7 stall drops with grant", stall, 0);
  endtask

  task automatic t_release();
    int lat, kind; bit s, b;
    do_rel(16'h0034, lat, kind);
    check(kind == 0 && lat == 2, "R8 writer release completes", lat, 2);
    check(gmem[8'h34] == {8'd2, 8'd0}, "R8 writer release record", gmem[8'h34], {8'd2, 8'd0});
    do_rel(16'h0012, lat, kind);
    check(kind == 0 && lat == 2, "R8 reader release completes", lat, 2);
    check(gmem[8'h12] == {8'd4, 8'd1}, "R8 reader release record", gmem[8'h12], {8'd4, 8'd1});
    do_req(16'h0012, 1'b0, -1, '0, lat, kind, s, b);
    check(kind == 0 && lat == 1, "R9 counters drop on release", lat, 1);
    do_req(16'h0034, 1'b1, -1, '0, lat, kind, s, b);
    check(kind == 0 && lat == 1, "R9 second address also cleared", lat, 1);
  endtask

  task automatic t_full_and_saturate();
    int lat, kind; bit s, b;
    do_load(16'h0010, 8'd0, 8'd1, 8'd0, 8'd0, 1'b0);
    do_load(16'h0110, 8'd0, 8'd1, 8'd0, 8'd0, 1'b0);
    do_load(16'h0210, 8'd0, 8'd1, 8'd0, 8'd0, 1'b0);
    do_load(16'h0310, 8'd0, 8'd1, 8'd0, 8'd0, 1'b0);
    do_load(16'h0077, 8'd0, 8'd1, 8'd0, 8'd0, 1'b0);
    do_req(16'h0077, 1'b0, -1, '0, lat, kind, s, b);
    check(kind == 0 && lat == 1, "R10 load into full table dropped", lat, 1);
    do_rel(16'h0010, lat, kind);
    do_rel(16'h0110, lat, kind);
    do_rel(16'h0210, lat, kind);
    do_rel(16'h0310, lat, kind);
    check(kind == 0, "R8 releases of all entries complete", kind, 0);
    do_req(16'h0410, 1'b0, -1, '0, lat, kind, s, b);
    check(kind == 1 && lat == 1, "R9 saturated counters stay set", kind, 1);
  endtask

  task automatic t_priority();
    int lat; bit g;
    do_load(16'h0056, 8'd0, 8'd9, 8'd0, 8'd0, 1'b0);
    gmem[8'h56] = {8'd0, 8'd0};
    @(negedge clk);
    req_valid = 1; req_addr = 16'h0033; req_write = 0;
    rel_valid = 1; rel_addr = 16'h0056;
    @(negedge clk);
    req_valid = 0; rel_valid = 0;
    g = grant;
    check(g, "R11 request wins over release", g, 1);
    for (lat = 0; lat < 4; lat++) @(negedge clk);
    check(gmem[8'h56] == {8'd0, 8'd0}, "R11 simultaneous release not taken", gmem[8'h56], 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset_and_miss();
    t_hit_read();
    t_false_pos_trap();
    t_write_rule();
    t_read_stall();
    t_release();
    t_full_and_saturate();
    t_priority();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule